// File: doc/BRIEF.md
# Redundant-Weight Successive-Approximation Sequencer

This block is the digital half of a successive-approximation converter. It does not halve the reference at each step. Instead, it moves the reference by a weight taken from a small loadable table. It may also spend more comparison steps than the output word has bits. The analog parts sit outside the block: the DAC, the comparator and the sample-and-hold. The block drives a signed reference code to the DAC, samples one comparator bit per clock and records every decision. When the last step finishes, it produces a clamped N-bit result and pulses a done flag.

Software or a neighbouring block first writes the step weights through a simple write port. It then pulses start together with a step count. Each conversion is formed from a signed sum of the table weights. Because the weights overlap, a comparison that went the wrong way early can be recovered by the later steps, and the final code is still right.

Top module: `sar_redund_ctrl`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `result_o`, `dec_bits_o` and `dac_code_o` are all zero.
- R2: A `start_i` seen while idle makes the block busy on the next clock. In that cycle `dac_code_o` equals weight entry 0.
- R3: In every step except the last, the next `dac_code_o` is the current code plus the next table weight if `cmp_above_i` was 1, or minus that weight if it was 0. Exactly one update happens per clock.
- R4: Each decision bit is 1 when the comparator reported the input above the reference and 0 when it reported below. The first step lands in bit M-1 and the last step in bit 0. Bits above M-1 are 0, and all bits are cleared at start.
- R5: The result is the last reference when the last decision is 1, and one less than it when the last decision is 0. It is then clamped to 0..2^N-1. The result holds until the next conversion ends.
- R6: With weights 16,10,6,3,2,1 and an input of 6.3, a wrong "below" decision on step 2 gives bits 001111 and the result 6. The correct run gives bits 010001 and the result 6.
- R7: The binary set 16,8,4,2,1, the set 16,10,6,3,2,1, the set 16,8,5,3,2,1,1 and the set 16,4,4,2,2,1,1,1 all convert every input v+0.3 (v in 0..31) to v. With the binary set, 7.3 gives bits 00111.
- R8: `done_o` is high for exactly one clock. It rises M clocks after the clock that accepted start, and `busy_o` is low while it is high.
- R9: A `start_i` seen while busy is ignored. The running conversion's step count, decisions and result are unchanged.
- R10: A weight write while busy is ignored. Neither the running conversion nor later conversions see it.
- R11: A requested step count of 0 runs 1 step. A count above the table depth runs the full depth.
- R12: The reference is signed and wide enough to go below 0 or above 2^N-1 without wrapping. For example, with weights 16,16,16 and an input below every level, the third step presents -16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (taken only when idle) |
| steps_i | input | STEP_W | Requested number of steps M |
| cmp_above_i | input | 1 | Comparator: 1 when input is above `dac_code_o` |
| wgt_we_i | input | 1 | Weight table write enable |
| wgt_idx_i | input | IDX_W | Weight table entry (0 = first step) |
| wgt_val_i | input | WGT_W | Unsigned weight value |
| dac_code_o | output | REF_W | Signed reference level for the DAC |
| busy_o | output | 1 | Conversion in progress |
| dec_bits_o | output | MAX_STEPS | Raw decision bits, first step most significant |
| result_o | output | DATA_W | Corrected, clamped result |
| done_o | output | 1 | One-clock pulse when `result_o` is new |

## Verification
Some rules are checked by the in-RTL assertions on every clock. These are:
- done lasting one cycle and never overlapping busy;
- start and table writes leaving the step count and the weights untouched while busy;
- the step counter staying below the latched count;
- the decision register starting empty;
- the result holding outside the final step.

The arithmetic itself can only be shown by the bench's scenarios. That covers the signed add/subtract trace, the half-LSB rounding of the last decision, the clamping and recovery from a misjudged step. The bench compares the DAC trace, bits and result against an independent model across four weight sets and full input sweeps.

// File: rtl/sar_redund_pkg.sv
package sar_redund_pkg;

    localparam int DEF_DATA_W    = 5;
    localparam int DEF_MAX_STEPS = 8;
    localparam int DEF_WGT_W     = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Per-cycle control handed from the sequencer to the datapath
    typedef struct packed {
        logic load;    // accept start: seed reference with entry 0
        logic active;  // a decision is taken this cycle
        logic last;    // this decision is the final one
    } seq_ctl_t;

    // Requested step count mapped into 1..max_steps
    function automatic int unsigned fit_steps(int unsigned req, int unsigned max_steps);
        if (req == 0)              return 1;
        else if (req > max_steps)  return max_steps;
        else                       return req;
    endfunction

endpackage

// File: rtl/sar_wgt_table.sv
module sar_wgt_table #(
    parameter int DEPTH = 8,
    parameter int WGT_W = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WGT_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WGT_W-1:0] rd_val
);

    logic [WGT_W-1:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            logic hit;
            assign hit = wr_en && !lock && (wr_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (rst)      mem[g] <= '0;
                else if (hit) mem[g] <= wr_val;
            end

            // R10: a locked table keeps every entry
            assert_locked_entry_R10: assert property (@(posedge clk) disable iff (rst)
                lock |=> $stable(mem[g]));
        end
    endgenerate

    assign rd_val = mem[rd_idx];

endmodule

// File: rtl/sar_step_seq.sv
module sar_step_seq
    import sar_redund_pkg::*;
#(
    parameter int MAX_STEPS = 8,
    parameter int STEP_W    = 4,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [STEP_W-1:0] req_steps,
    output seq_ctl_t          ctl,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy,
    output logic              done
);

    seq_state_e        state;
    logic [IDX_W-1:0]  step_idx;
    logic [STEP_W-1:0] steps_eff;
    logic [STEP_W-1:0] req_fit;
    logic              at_last;

    assign req_fit = STEP_W'(fit_steps(int'(req_steps), MAX_STEPS));
    assign at_last = (STEP_W'(step_idx) + STEP_W'(1)) == steps_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step_idx  <= '0;
            steps_eff <= STEP_W'(1);
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_RUN;
                        step_idx  <= '0;
                        steps_eff <= req_fit;
                    end
                end
                ST_RUN: begin
                    if (at_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        step_idx <= step_idx + IDX_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load   = (state == ST_IDLE) && start;
        ctl.active = (state == ST_RUN);
        ctl.last   = (state == ST_RUN) && at_last;
        rd_idx     = ctl.load ? '0 : step_idx + IDX_W'(1);
    end

    assign busy = (state == ST_RUN);

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: an accepted start makes the block busy next cycle
    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R9: a start during a conversion leaves the step count alone
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(steps_eff));

    // R11: latched step count stays within 1..MAX_STEPS, index below it
    assert_step_bound_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (steps_eff != 0) && (int'(steps_eff) <= MAX_STEPS)
                 && (STEP_W'(step_idx) < steps_eff));

endmodule

// File: rtl/sar_ref_accum.sv
module sar_ref_accum
    import sar_redund_pkg::*;
#(
    parameter int DATA_W    = 5,
    parameter int WGT_W     = 8,
    parameter int REF_W     = 12,
    parameter int MAX_STEPS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  seq_ctl_t                ctl,
    input  logic [WGT_W-1:0]        weight,
    input  logic                    cmp_above,
    output logic signed [REF_W-1:0] ref_lvl,
    output logic [MAX_STEPS-1:0]    bits,
    output logic [DATA_W-1:0]       result
);

    localparam logic signed [REF_W-1:0] MAX_CODE = REF_W'((1 << DATA_W) - 1);

    logic signed [REF_W-1:0] wext;
    logic signed [REF_W-1:0] ref_next;
    logic signed [REF_W-1:0] fin_val;
    logic [DATA_W-1:0]       fin_clamped;

    assign wext = $signed({{(REF_W-WGT_W){1'b0}}, weight});

    always_comb begin
        ref_next = cmp_above ? (ref_lvl + wext) : (ref_lvl - wext);
        // +/- half LSB from the final decision, then the fixed -1/2 offset
        fin_val  = cmp_above ? ref_lvl : (ref_lvl - REF_W'(1));
        if (fin_val < 0)              fin_clamped = '0;
        else if (fin_val > MAX_CODE)  fin_clamped = MAX_CODE[DATA_W-1:0];
        else                          fin_clamped = fin_val[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_lvl <= '0;
            bits    <= '0;
            result  <= '0;
        end else if (ctl.load) begin
            ref_lvl <= wext;
            bits    <= '0;
        end else if (ctl.active) begin
            bits <= {bits[MAX_STEPS-2:0], cmp_above};
            if (ctl.last) result  <= fin_clamped;
            else          ref_lvl <= ref_next;
        end
    end

    // R4: decision record is empty right after a conversion is seeded
    assert_bits_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (bits == '0));

    // R5: the result only changes on the final decision
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl.last |=> $stable(result));

    // R3: the reference never moves when no decision is taken
    assert_ref_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.active) |=> $stable(ref_lvl));

endmodule

// File: rtl/sar_redund_ctrl.sv
module sar_redund_ctrl
    import sar_redund_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int MAX_STEPS = DEF_MAX_STEPS,
    parameter int WGT_W     = DEF_WGT_W,
    localparam int STEP_W   = $clog2(MAX_STEPS + 1),
    localparam int IDX_W    = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1,
    localparam int REF_W    = WGT_W + $clog2(MAX_STEPS) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [STEP_W-1:0]       steps_i,
    input  logic                    cmp_above_i,
    input  logic                    wgt_we_i,
    input  logic [IDX_W-1:0]        wgt_idx_i,
    input  logic [WGT_W-1:0]        wgt_val_i,
    output logic signed [REF_W-1:0] dac_code_o,
    output logic                    busy_o,
    output logic [MAX_STEPS-1:0]    dec_bits_o,
    output logic [DATA_W-1:0]       result_o,
    output logic                    done_o
);

    seq_ctl_t         ctl;
    logic [IDX_W-1:0] rd_idx;
    logic [WGT_W-1:0] rd_val;

    sar_step_seq #(
        .MAX_STEPS (MAX_STEPS),
        .STEP_W    (STEP_W),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .req_steps (steps_i),
        .ctl       (ctl),
        .rd_idx    (rd_idx),
        .busy      (busy_o),
        .done      (done_o)
    );

    sar_wgt_table #(
        .DEPTH (MAX_STEPS),
        .WGT_W (WGT_W),
        .IDX_W (IDX_W)
    ) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .lock   (busy_o),
        .wr_en  (wgt_we_i),
        .wr_idx (wgt_idx_i),
        .wr_val (wgt_val_i),
        .rd_idx (rd_idx),
        .rd_val (rd_val)
    );

    sar_ref_accum #(
        .DATA_W    (DATA_W),
        .WGT_W     (WGT_W),
        .REF_W     (REF_W),
        .MAX_STEPS (MAX_STEPS)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .weight    (rd_val),
        .cmp_above (cmp_above_i),
        .ref_lvl   (dac_code_o),
        .bits      (dec_bits_o),
        .result    (result_o)
    );

    // R8: done never coincides with an active conversion
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8: done only rises out of a conversion that was running
    assert_done_from_run_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy_o));

endmodule

// File: tb/sar_redund_ctrl_tb_top.sv
module sar_redund_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 5;
    localparam int MS = 8;
    localparam int WW = 8;
    localparam int SW = 4;
    localparam int IW = 3;
    localparam int RW = 12;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start_i = 1'b0;
    logic [SW-1:0]        steps_i = '0;
    logic                 cmp_above_i = 1'b0;
    logic                 wgt_we_i = 1'b0;
    logic [IW-1:0]        wgt_idx_i = '0;
    logic [WW-1:0]        wgt_val_i = '0;
    logic signed [RW-1:0] dac_code_o;
    logic                 busy_o;
    logic [MS-1:0]        dec_bits_o;
    logic [DW-1:0]        result_o;
    logic                 done_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int w  [MS];
    int obs[MS];

    sar_redund_ctrl dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .steps_i(steps_i),
        .cmp_above_i(cmp_above_i), .wgt_we_i(wgt_we_i), .wgt_idx_i(wgt_idx_i),
        .wgt_val_i(wgt_val_i), .dac_code_o(dac_code_o), .busy_o(busy_o),
        .dec_bits_o(dec_bits_o), .result_o(result_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff_steps(input int req);
        if (req == 0) return 1;
        if (req > MS) return MS;
        return req;
    endfunction

    // Independent reference of the conversion rules (R3, R4, R5)
    task automatic model(input int m, input int vin10, input logic [7:0] fmask,
                         input logic [7:0] fval, output int bits, output int res,
                         output int trace[MS]);
        int r;
        int fin;
        bit d;
        r = w[0];
        bits = 0;
        fin = 0;
        for (int k = 0; k < MS; k++) trace[k] = 0;
        for (int k = 0; k < m; k++) begin
            trace[k] = r;
            d = fmask[k] ? fval[k] : (vin10 > r * 10);
            bits = (bits << 1) | int'(d);
            if (k < m - 1) r = d ? r + w[k+1] : r - w[k+1];
            else           fin = d ? r : r - 1;
        end
        if (fin < 0) fin = 0;
        if (fin > (1 << DW) - 1) fin = (1 << DW) - 1;
        res = fin;
    endtask

    task automatic load_set(input int a0, a1, a2, a3, a4, a5, a6, a7);
        int v[MS];
        v = '{a0, a1, a2, a3, a4, a5, a6, a7};
        for (int i = 0; i < MS; i++) begin
            @(negedge clk);
            wgt_we_i  = 1'b1;
            wgt_idx_i = IW'(i);
            wgt_val_i = WW'(v[i]);
            w[i] = v[i];
        end
        @(negedge clk);
        wgt_we_i = 1'b0;
    endtask

    // inject: 0 none, 1 start while busy, 2 weight write while busy
    task automatic run_conv(input int vin10, input int mcfg, input logic [7:0] fmask,
                            input logic [7:0] fval, input int inject,
                            output int got_bits, output int got_res);
        int m, eb, er, n;
        int tr[MS];
        bit trace_ok;
        bit d;
        m = eff_steps(mcfg);
        model(m, vin10, fmask, fval, eb, er, tr);
        @(negedge clk);
        steps_i = SW'(mcfg);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        check(int'(dac_code_o) == w[0], "R2 first reference", int'(dac_code_o), w[0]);
        n = 0;
        while (!done_o && n < 20) begin
            if (n < MS) obs[n] = int'(dac_code_o);
            d = (n < MS && fmask[n]) ? fval[n] : (vin10 > int'(dac_code_o) * 10);
            cmp_above_i = d;
            if (inject == 1 && n == 1) begin start_i = 1'b1; steps_i = SW'(1); end
            if (inject == 2 && n == 1) begin
                wgt_we_i = 1'b1; wgt_idx_i = IW'(2); wgt_val_i = '0;
            end
            @(negedge clk);
            start_i  = 1'b0;
            wgt_we_i = 1'b0;
            n++;
        end
        check(n == m, "R8 latency start to done", n, m);
        trace_ok = 1'b1;
        for (int k = 0; k < m && k < MS; k++) if (obs[k] != tr[k]) trace_ok = 1'b0;
        check(trace_ok, "R3 reference trace", obs[m-1], tr[m-1]);
        check(int'(dec_bits_o) == eb, "R4 decision bits", int'(dec_bits_o), eb);
        check(int'(result_o) == er, "R5 corrected result", int'(result_o), er);
        check(busy_o == 1'b0, "R8 not busy with done", int'(busy_o), 0);
        got_bits = int'(dec_bits_o);
        got_res  = int'(result_o);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done single cycle", int'(done_o), 0);
        check(int'(result_o) == er, "R5 result holds", int'(result_o), er);
    endtask

    task automatic t_reset();
        check(done_o == 1'b0 && busy_o == 1'b0, "R1 idle flags", int'({done_o, busy_o}), 0);
        check(result_o == '0, "R1 result zero", int'(result_o), 0);
        check(dec_bits_o == '0, "R1 bits zero", int'(dec_bits_o), 0);
        check(dac_code_o == '0, "R1 dac zero", int'(dac_code_o), 0);
    endtask

    task automatic t_examples();
        int b, r;
        load_set(16, 8, 4, 2, 1, 0, 0, 0);
        run_conv(73, 5, 8'h00, 8'h00, 0, b, r);
        check(b == 'b00111, "R7 binary 7.3 bits", b, 'b00111);
        check(r == 7, "R7 binary 7.3 result", r, 7);
        load_set(16, 10, 6, 3, 2, 1, 0, 0);
        run_conv(63, 6, 8'h00, 8'h00, 0, b, r);
        check(b == 'b010001, "R6 clean bits", b, 'b010001);
        check(r == 6, "R6 clean result", r, 6);
        // step index 1 forced to "below"
        run_conv(63, 6, 8'h02, 8'h00, 0, b, r);
        check(b == 'b001111, "R6 misjudged bits", b, 'b001111);
        check(r == 6, "R6 misjudged result", r, 6);
    endtask

    task automatic t_sweep(input int m);
        int b, r;
        for (int v = 0; v < 32; v++) begin
            run_conv(v * 10 + 3, m, 8'h00, 8'h00, 0, b, r);
            check(r == v, "R7 sweep result", r, v);
        end
    endtask

    task automatic t_clamp();
        int b, r;
        load_set(16, 16, 16, 0, 0, 0, 0, 0);
        run_conv(500, 3, 8'h00, 8'h00, 0, b, r);
        check(r == 31, "R5 clamp high", r, 31);
        check(obs[2] == 48, "R12 reference above range", obs[2], 48);
        run_conv(0, 3, 8'h00, 8'h00, 0, b, r);
        check(r == 0, "R5 clamp low", r, 0);
        check(obs[2] == -16, "R12 reference below zero", obs[2], -16);
    endtask

    task automatic t_step_limits();
        int b, r;
        load_set(16, 8, 5, 3, 2, 1, 1, 0);
        run_conv(203, 0, 8'h00, 8'h00, 0, b, r);
        check(r == 16 && b == 1, "R11 zero steps runs one", r, 16);
        run_conv(53, 0, 8'h00, 8'h00, 0, b, r);
        check(r == 15 && b == 0, "R11 zero steps below", r, 15);
        load_set(16, 4, 4, 2, 2, 1, 1, 1);
        run_conv(183, 15, 8'h00, 8'h00, 0, b, r);
        check(r == 18, "R11 oversize count uses depth", r, 18);
    endtask

    task automatic t_busy_ignore();
        int b, r;
        load_set(16, 10, 6, 3, 2, 1, 0, 0);
        run_conv(213, 6, 8'h00, 8'h00, 1, b, r);
        check(r == 21, "R9 start during run ignored", r, 21);
        run_conv(213, 6, 8'h00, 8'h00, 2, b, r);
        check(r == 21, "R10 write during run ignored", r, 21);
        // the later conversion still sees the original entry 2 (w[2]=6)
        run_conv(63, 6, 8'h00, 8'h00, 0, b, r);
        check(obs[2] == 12, "R10 table unchanged after run", obs[2], 12);
        check(r == 6, "R10 result with original table", r, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_examples();
        load_set(16, 8, 4, 2, 1, 0, 0, 0);
        t_sweep(5);
        load_set(16, 10, 6, 3, 2, 1, 0, 0);
        t_sweep(6);
        load_set(16, 8, 5, 3, 2, 1, 1, 0);
        t_sweep(7);
        load_set(16, 4, 4, 2, 2, 1, 1, 1);
        t_sweep(8);
        t_clamp();
        t_step_limits();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule